// File: doc/BRIEF.md
# Hardwired Step-Sequenced Control Unit

This block is the control unit for a processor whose registers, ALU and memory interface share one internal bus. A step counter advances once per clock and is decoded into one-hot step lines. An opcode decoder turns the instruction register's opcode field into one line per instruction. A sum-of-products encoder combines the step lines, the opcode lines, the negative flag and the memory-complete input into the individual strobes that gate registers onto and off the bus.

Every instruction begins with a shared three-step fetch. That fetch reads memory at the program counter, advances the program counter by four through the ALU, and loads the instruction register. Four instructions follow it:
- an add whose operand sits at the address held in R3;
- the same add with R3 advanced by four;
- an unconditional relative jump;
- a jump taken only when the negative flag is set.

Any other opcode ends straight after the fetch. The datapath and memory are outside the block.

The counter has three named actions: CLEAR (reset, or End while running), HOLD (run low, or a memory wait with memory-complete low) and STEP (advance to the next step). CLEAR returns to step 1. HOLD keeps the current step, and with it every strobe of that step. STEP moves to the next step line.

Top module: `hw_step_ctrl`

## Requirements
- R1: A synchronous `rst` high at a clock edge puts the counter in step 1 (`tstep` = 8'b0000_0001). This holds also in the middle of an instruction.
- R2: Bit k of `tstep` is high during step k+1, and exactly one bit is high. Each step lasts one clock cycle unless held.
- R3: While `run` is low, the step does not change and all strobes of the current step stay asserted. This holds even when `step_end` or `wmfc` is high.
- R4: In a step with `wmfc` high, the counter holds while `mfc` is 0 and advances on the first edge with `mfc` at 1. The step's other strobes stay asserted throughout.
- R5: An edge with `run` high and `step_end` high returns the counter to step 1.
- R6: The fetch steps are the same for every opcode:
  - step 1: `pc_out`, `mar_in`, `mem_rd`, `sel_four`, `alu_add`, `z_in`;
  - step 2: `z_out`, `pc_in`, `y_in`, `mdr_ld_ext`, `wmfc`;
  - step 3: `mdr_out`, `ir_in`.
- R7: For opcode 4'd1 (indirect add), the steps after fetch are:
  - step 4: `r3_out`, `mar_in`, `mem_rd`;
  - step 5: `r1_out`, `y_in`, `mdr_ld_ext`, `wmfc`;
  - step 6: `mdr_out`, `alu_add`, `z_in` (with `sel_four` low, the ALU takes Y);
  - step 7: `z_out`, `r1_in`, `step_end`.
- R8: For opcode 4'd2 (autoincrement add), the steps after fetch are:
  - step 4: `r3_out`, `mar_in`, `mem_rd`, `sel_four`, `alu_add`, `z_in`;
  - step 5: `z_out`, `r3_in`;
  - step 6: `r1_out`, `y_in`, `mdr_ld_ext`, `wmfc`;
  - step 7: `mdr_out`, `alu_add`, `z_in`;
  - step 8: `z_out`, `r1_in`, `step_end`.
- R9: For opcode 4'd3 (jump), the steps after fetch are:
  - step 4: `off_out`, `alu_add`, `z_in`, which adds the offset to the updated PC held in Y;
  - step 5: `z_out`, `pc_in`, `step_end`.
- R10: For opcode 4'd4, the step-4 level of `flag_n` picks the path:
  - `flag_n` = 1: the R9 sequence;
  - `flag_n` = 0: step 4 asserts only `step_end`.
- R11: Any other opcode value (4'd0, 4'd5 to 4'd15) asserts only `step_end` in step 4.
- R12: At most one of `pc_out`, `mdr_out`, `z_out`, `r1_out`, `r3_out`, `off_out` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset to step 1 |
| run | input | 1 | Counter enable; low holds the step |
| op | input | 4 | Opcode field of the instruction register |
| flag_n | input | 1 | Negative condition flag |
| mfc | input | 1 | Memory function complete |
| tstep | output | NSTEP | One-hot step lines |
| pc_out | output | 1 | PC drives the bus |
| pc_in | output | 1 | PC loads from the bus |
| mar_in | output | 1 | Address register loads from the bus |
| mem_rd | output | 1 | Memory read request |
| mdr_out | output | 1 | Data register drives the internal bus |
| mdr_ld_ext | output | 1 | Data register loads from the memory bus |
| ir_in | output | 1 | Instruction register loads |
| y_in | output | 1 | Y register loads |
| sel_four | output | 1 | ALU input A takes constant 4 (low: Y) |
| alu_add | output | 1 | ALU adds |
| z_in | output | 1 | Z loads the ALU result |
| z_out | output | 1 | Z drives the bus |
| r1_out | output | 1 | R1 drives the bus |
| r1_in | output | 1 | R1 loads |
| r3_out | output | 1 | R3 drives the bus |
| r3_in | output | 1 | R3 loads |
| off_out | output | 1 | Instruction offset field drives the bus |
| wmfc | output | 1 | Wait for memory completion |
| step_end | output | 1 | Last step of the instruction |

## Verification
The hardest situations to reach are the overlaps of the three counter actions. One is a stall with `run` low that lands inside a memory wait. Another is a reset in the middle of the eight-step autoincrement sequence. The driver task takes the number of wait cycles, the step and length of a run-low stall, and a reset step as arguments, so each overlap is set up directly. The expected strobes are queued for every held cycle.

// File: rtl/hw_ctl_pkg.sv
package hw_ctl_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OPC_ADD_IND  = 4'd1,
        OPC_ADD_AUTO = 4'd2,
        OPC_JMP      = 4'd3,
        OPC_JMP_NEG  = 4'd4
    } opc_e;

    typedef struct packed {
        logic add_ind;
        logic add_auto;
        logic jmp;
        logic jmp_neg;
        logic other;
    } opln_t;

    typedef struct packed {
        logic pc_out;
        logic pc_in;
        logic mar_in;
        logic mem_rd;
        logic mdr_out;
        logic mdr_ld_ext;
        logic ir_in;
        logic y_in;
        logic sel_four;
        logic alu_add;
        logic z_in;
        logic z_out;
        logic r1_out;
        logic r1_in;
        logic r3_out;
        logic r3_in;
        logic off_out;
        logic wmfc;
        logic step_end;
    } ctl_t;

    typedef enum logic [1:0] {
        ACT_CLEAR,
        ACT_HOLD,
        ACT_STEP
    } act_e;

endpackage

// File: rtl/hw_step_counter.sv
module hw_step_counter
    import hw_ctl_pkg::*;
#(
    parameter int NSTEP = 8,
    localparam int CW = (NSTEP > 1) ? $clog2(NSTEP) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          done,
    input  logic          wait_req,
    input  logic          mfc,
    output logic [CW-1:0] cnt
);

    act_e act;

    // Priority: reset, run-low hold, End, memory wait, advance.
    always_comb begin
        if (rst)                     act = ACT_CLEAR;
        else if (!run)               act = ACT_HOLD;
        else if (done)               act = ACT_CLEAR;
        else if (wait_req && !mfc)   act = ACT_HOLD;
        else                         act = ACT_STEP;
    end

    always_ff @(posedge clk) begin
        unique case (act)
            ACT_CLEAR: cnt <= '0;
            ACT_HOLD:  cnt <= cnt;
            ACT_STEP:  cnt <= (cnt == CW'(NSTEP - 1)) ? '0 : cnt + 1'b1;
            default:   cnt <= '0;
        endcase
    end

endmodule

// File: rtl/hw_step_decoder.sv
module hw_step_decoder #(
    parameter int NSTEP = 8,
    localparam int CW = (NSTEP > 1) ? $clog2(NSTEP) : 1
) (
    input  logic [CW-1:0]    cnt,
    output logic [NSTEP-1:0] t
);

    for (genvar k = 0; k < NSTEP; k++) begin : g_line
        assign t[k] = (cnt == CW'(k));
    end

endmodule

// File: rtl/hw_op_decoder.sv
module hw_op_decoder
    import hw_ctl_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output opln_t           lines
);

    always_comb begin
        lines = '0;
        unique case (op)
            OPC_ADD_IND:  lines.add_ind  = 1'b1;
            OPC_ADD_AUTO: lines.add_auto = 1'b1;
            OPC_JMP:      lines.jmp      = 1'b1;
            OPC_JMP_NEG:  lines.jmp_neg  = 1'b1;
            default:      lines.other    = 1'b1;
        endcase
    end

endmodule

// File: rtl/hw_ctl_encoder.sv
module hw_ctl_encoder
    import hw_ctl_pkg::*;
#(
    parameter int NSTEP = 8
) (
    input  logic [NSTEP-1:0] t,
    input  opln_t            lines,
    input  logic             flag_n,
    output ctl_t             ctl
);

    logic ai, aa, jt4, jn4, j5, mem_op;

    always_comb begin
        ai     = lines.add_ind;
        aa     = lines.add_auto;
        // Flag is sampled in step 4 only; step 5 exists only on the taken path.
        jt4    = lines.jmp | (lines.jmp_neg & flag_n);
        jn4    = lines.jmp_neg & ~flag_n;
        j5     = lines.jmp | lines.jmp_neg;
        mem_op = ai | aa;

        ctl.pc_out     = t[0];
        ctl.pc_in      = t[1] | (t[4] & j5);
        ctl.mar_in     = t[0] | (t[3] & mem_op);
        ctl.mem_rd     = t[0] | (t[3] & mem_op);
        ctl.mdr_out    = t[2] | (t[5] & ai) | (t[6] & aa);
        ctl.mdr_ld_ext = t[1] | (t[4] & ai) | (t[5] & aa);
        ctl.wmfc       = t[1] | (t[4] & ai) | (t[5] & aa);
        ctl.ir_in      = t[2];
        ctl.y_in       = t[1] | (t[4] & ai) | (t[5] & aa);
        ctl.sel_four   = t[0] | (t[3] & aa);
        ctl.alu_add    = t[0] | (t[3] & (aa | jt4)) | (t[5] & ai) | (t[6] & aa);
        ctl.z_in       = t[0] | (t[3] & (aa | jt4)) | (t[5] & ai) | (t[6] & aa);
        ctl.z_out      = t[1] | (t[4] & (aa | j5)) | (t[6] & ai) | (t[7] & aa);
        ctl.r1_out     = (t[4] & ai) | (t[5] & aa);
        ctl.r1_in      = (t[6] & ai) | (t[7] & aa);
        ctl.r3_out     = t[3] & mem_op;
        ctl.r3_in      = t[4] & aa;
        ctl.off_out    = t[3] & jt4;
        ctl.step_end   = (t[6] & ai) | (t[7] & aa) | (t[4] & j5)
                       | (t[3] & (jn4 | lines.other));
    end

endmodule

// File: rtl/hw_step_ctrl.sv
module hw_step_ctrl
    import hw_ctl_pkg::*;
#(
    parameter int NSTEP = 8,
    localparam int CW = (NSTEP > 1) ? $clog2(NSTEP) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [3:0]       op,
    input  logic             flag_n,
    input  logic             mfc,
    output logic [NSTEP-1:0] tstep,
    output logic             pc_out,
    output logic             pc_in,
    output logic             mar_in,
    output logic             mem_rd,
    output logic             mdr_out,
    output logic             mdr_ld_ext,
    output logic             ir_in,
    output logic             y_in,
    output logic             sel_four,
    output logic             alu_add,
    output logic             z_in,
    output logic             z_out,
    output logic             r1_out,
    output logic             r1_in,
    output logic             r3_out,
    output logic             r3_in,
    output logic             off_out,
    output logic             wmfc,
    output logic             step_end
);

    logic [CW-1:0] cnt;
    opln_t         lines;
    ctl_t          ctl;

    hw_step_counter #(.NSTEP(NSTEP)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .done     (ctl.step_end),
        .wait_req (ctl.wmfc),
        .mfc      (mfc),
        .cnt      (cnt)
    );

    hw_step_decoder #(.NSTEP(NSTEP)) u_sdec (
        .cnt (cnt),
        .t   (tstep)
    );

    hw_op_decoder u_odec (
        .op    (op),
        .lines (lines)
    );

    hw_ctl_encoder #(.NSTEP(NSTEP)) u_enc (
        .t      (tstep),
        .lines  (lines),
        .flag_n (flag_n),
        .ctl    (ctl)
    );

    assign pc_out     = ctl.pc_out;
    assign pc_in      = ctl.pc_in;
    assign mar_in     = ctl.mar_in;
    assign mem_rd     = ctl.mem_rd;
    assign mdr_out    = ctl.mdr_out;
    assign mdr_ld_ext = ctl.mdr_ld_ext;
    assign ir_in      = ctl.ir_in;
    assign y_in       = ctl.y_in;
    assign sel_four   = ctl.sel_four;
    assign alu_add    = ctl.alu_add;
    assign z_in       = ctl.z_in;
    assign z_out      = ctl.z_out;
    assign r1_out     = ctl.r1_out;
    assign r1_in      = ctl.r1_in;
    assign r3_out     = ctl.r3_out;
    assign r3_in      = ctl.r3_in;
    assign off_out    = ctl.off_out;
    assign wmfc       = ctl.wmfc;
    assign step_end   = ctl.step_end;

endmodule

// File: rtl/hw_step_ctrl_chk.sv
module hw_step_ctrl_chk #(
    parameter int NSTEP = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic [3:0]       op,
    input logic             flag_n,
    input logic             mfc,
    input logic [NSTEP-1:0] tstep,
    input logic             pc_out,
    input logic             mar_in,
    input logic             mem_rd,
    input logic             mdr_out,
    input logic             sel_four,
    input logic             alu_add,
    input logic             z_in,
    input logic             z_out,
    input logic             r1_out,
    input logic             r3_out,
    input logic             off_out,
    input logic             wmfc,
    input logic             step_end
);

    // R2: one step line at a time
    a_r2_onehot_step: assert property (@(posedge clk) disable iff (rst)
        $countones(tstep) == 1);

    // R2: plain advance moves to the next line
    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        (run && !step_end && !(wmfc && !mfc) && !tstep[NSTEP-1])
        |=> (tstep == ($past(tstep) << 1)));

    // R3: run low freezes the step
    a_r3_run_hold: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(tstep));

    // R4: memory wait freezes the step
    a_r4_wait_hold: assert property (@(posedge clk) disable iff (rst)
        (wmfc && !mfc) |=> $stable(tstep));

    // R5: End goes back to step 1
    a_r5_end_to_fetch: assert property (@(posedge clk) disable iff (rst)
        (run && step_end) |=> tstep[0]);

    // R6: first fetch step strobes
    a_r6_fetch_first: assert property (@(posedge clk) disable iff (rst)
        tstep[0] |-> (pc_out && mar_in && mem_rd && sel_four && alu_add && z_in));

    // R10: untaken conditional jump ends in step 4
    a_r10_untaken_end: assert property (@(posedge clk) disable iff (rst)
        (tstep[3] && op == 4'd4 && !flag_n) |-> (step_end && !off_out));

    // R12: a single bus driver
    a_r12_one_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pc_out, mdr_out, z_out, r1_out, r3_out, off_out}));

endmodule

bind hw_step_ctrl hw_step_ctrl_chk #(.NSTEP(NSTEP)) u_chk (.*);

// File: tb/sim_hw_step_ctrl.sv
module sim_hw_step_ctrl;

    localparam int NS = 8;
    // bench bit positions for the expected strobe word
    localparam int B_END = 0,  B_WMFC = 1, B_OFF = 2,  B_R3I = 3,  B_R3O = 4;
    localparam int B_R1I = 5,  B_R1O = 6,  B_ZO = 7,   B_ZI = 8,   B_ADD = 9;
    localparam int B_S4 = 10,  B_YI = 11,  B_IRI = 12, B_MDE = 13, B_MDO = 14;
    localparam int B_RD = 15,  B_MARI = 16, B_PCI = 17, B_PCO = 18;

    logic clk = 1'b0;
    logic rst, run, flag_n, mfc;
    logic [3:0] op;
    logic [NS-1:0] tstep;
    logic pc_out, pc_in, mar_in, mem_rd, mdr_out, mdr_ld_ext, ir_in, y_in;
    logic sel_four, alu_add, z_in, z_out, r1_out, r1_in, r3_out, r3_in;
    logic off_out, wmfc, step_end;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [NS+18:0] exp_q[$];
    string          tag_q[$];

    always #2 clk = ~clk;

    hw_step_ctrl #(.NSTEP(NS)) u0 (
        .clk(clk), .rst(rst), .run(run), .op(op), .flag_n(flag_n), .mfc(mfc),
        .tstep(tstep), .pc_out(pc_out), .pc_in(pc_in), .mar_in(mar_in),
        .mem_rd(mem_rd), .mdr_out(mdr_out), .mdr_ld_ext(mdr_ld_ext),
        .ir_in(ir_in), .y_in(y_in), .sel_four(sel_four), .alu_add(alu_add),
        .z_in(z_in), .z_out(z_out), .r1_out(r1_out), .r1_in(r1_in),
        .r3_out(r3_out), .r3_in(r3_in), .off_out(off_out), .wmfc(wmfc),
        .step_end(step_end)
    );

    function automatic logic [18:0] exp_ctl(input logic [3:0] o, input logic n, input int s);
        logic [18:0] w = '0;
        case (s)
            1: begin w[B_PCO]=1; w[B_MARI]=1; w[B_RD]=1; w[B_S4]=1; w[B_ADD]=1; w[B_ZI]=1; end
            2: begin w[B_ZO]=1; w[B_PCI]=1; w[B_YI]=1; w[B_MDE]=1; w[B_WMFC]=1; end
            3: begin w[B_MDO]=1; w[B_IRI]=1; end
            default: begin
                if (o == 4'd1) begin
                    case (s)
                        4: begin w[B_R3O]=1; w[B_MARI]=1; w[B_RD]=1; end
                        5: begin w[B_R1O]=1; w[B_YI]=1; w[B_MDE]=1; w[B_WMFC]=1; end
                        6: begin w[B_MDO]=1; w[B_ADD]=1; w[B_ZI]=1; end
                        7: begin w[B_ZO]=1; w[B_R1I]=1; w[B_END]=1; end
                        default: ;
                    endcase
                end else if (o == 4'd2) begin
                    case (s)
                        4: begin w[B_R3O]=1; w[B_MARI]=1; w[B_RD]=1; w[B_S4]=1; w[B_ADD]=1; w[B_ZI]=1; end
                        5: begin w[B_ZO]=1; w[B_R3I]=1; end
                        6: begin w[B_R1O]=1; w[B_YI]=1; w[B_MDE]=1; w[B_WMFC]=1; end
                        7: begin w[B_MDO]=1; w[B_ADD]=1; w[B_ZI]=1; end
                        8: begin w[B_ZO]=1; w[B_R1I]=1; w[B_END]=1; end
                        default: ;
                    endcase
                end else if (o == 4'd3 || (o == 4'd4 && n)) begin
                    case (s)
                        4: begin w[B_OFF]=1; w[B_ADD]=1; w[B_ZI]=1; end
                        5: begin w[B_ZO]=1; w[B_PCI]=1; w[B_END]=1; end
                        default: ;
                    endcase
                end else if (s == 4) begin
                    w[B_END] = 1;
                end
            end
        endcase
        return w;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input int s, input logic [18:0] w, input string tg);
        logic [NS-1:0] oh = NS'(1) << (s - 1);
        exp_q.push_back({oh, w});
        tag_q.push_back(tg);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Driver: steps one instruction, queuing the expected word of each cycle.
    task automatic run_instr(input logic [3:0] o, input logic n, input int waits,
                             input int stall_at, input int stall_len,
                             input int rst_at, input string tg);
        int s = 1;
        bit fin = 0;
        logic [18:0] w;
        op = o;
        flag_n = n;
        while (!fin) begin
            w = exp_ctl(o, n, s);
            if (s == rst_at) begin
                rst = 1'b1;
                push(s, w, "R1");
                tick();
                rst = 1'b0;
                fin = 1;
            end else begin
                if (s == stall_at) begin
                    for (int i = 0; i < stall_len; i++) begin
                        run = 1'b0; mfc = 1'b0;
                        push(s, w, "R3");
                        tick();
                    end
                end
                run = 1'b1;
                if (w[B_WMFC]) begin
                    for (int i = 0; i < waits; i++) begin
                        mfc = 1'b0;
                        push(s, w, "R4");
                        tick();
                    end
                end
                mfc = w[B_WMFC];
                push(s, w, (s <= 3) ? "R6/R2" : (w[B_END] ? {tg, "/R5"} : tg));
                tick();
                mfc = 1'b0;
                if (w[B_END]) fin = 1;
                else s++;
            end
        end
    endtask

    // Monitor: compare at the falling edge, away from the active edge.
    always @(negedge clk) begin
        logic [NS+18:0] got, exp;
        string tg;
        got = {tstep, pc_out, pc_in, mar_in, mem_rd, mdr_out, mdr_ld_ext, ir_in,
               y_in, sel_four, alu_add, z_in, z_out, r1_out, r1_in, r3_out,
               r3_in, off_out, wmfc, step_end};
        if (exp_q.size() > 0) begin
            exp = exp_q.pop_front();
            tg = tag_q.pop_front();
            checks++;
            if (got !== exp) begin
                errors++;
                $display("FAIL %s got=%b exp=%b", tg, got, exp);
            end
            // R12: bus drivers never overlap
            checks++;
            if ($countones({pc_out, mdr_out, z_out, r1_out, r3_out, off_out}) > 1) begin
                errors++;
                $display("FAIL R12 drivers got=%0d exp<=1",
                         $countones({pc_out, mdr_out, z_out, r1_out, r3_out, off_out}));
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                errors++;
                $display("FAIL watchdog got=%0d cycles exp<=20000", cyc);
                summary();
            end
        end
    end

    initial begin
        rst = 1'b1; run = 1'b1; op = 4'd0; flag_n = 1'b0; mfc = 1'b0;
        tick();
        push(1, exp_ctl(4'd0, 1'b0, 1), "R1");
        tick();
        rst = 1'b0;

        run_instr(4'd1, 1'b0, 0, 0, 0, 0, "R7");     // R7 no wait
        run_instr(4'd1, 1'b0, 3, 0, 0, 0, "R7");     // R4 waits in R7
        run_instr(4'd2, 1'b0, 2, 5, 3, 0, "R8");     // R3 stall at step 5
        run_instr(4'd2, 1'b0, 1, 2, 2, 0, "R8");     // R3 stall inside wait step
        run_instr(4'd3, 1'b0, 0, 0, 0, 0, "R9");
        run_instr(4'd4, 1'b1, 1, 0, 0, 0, "R10");    // taken
        run_instr(4'd4, 1'b0, 0, 0, 0, 0, "R10");    // not taken
        run_instr(4'd0, 1'b0, 0, 0, 0, 0, "R11");
        run_instr(4'd9, 1'b1, 2, 4, 2, 0, "R11");    // R3 stall over End
        run_instr(4'd2, 1'b0, 0, 0, 0, 6, "R8");     // R1 mid-instruction reset
        run_instr(4'd15, 1'b0, 0, 0, 0, 0, "R11");
        run_instr(4'd1, 1'b0, 1, 7, 2, 0, "R7");
        tick();
        summary();
    end

endmodule